// File: doc/BRIEF.md
# Parked Clock Source Selector

This controller picks which clock feeds a processor core. Five sources can be chosen: the system reference clock, a 32 kHz sleep clock, a first on-chip oscillator, and a second on-chip oscillator at either of two operating points. For the low-speed point the clock is divided by two (326 MHz becomes 163 MHz). The high-speed point runs undivided at 360 MHz. Every other source also runs undivided. The controller drives a source-select code to a glitch-free clock mux, together with a divide-by-two enable. It waits for the mux to acknowledge each new selection.

The second oscillator can be retuned. A request for either of its operating points therefore starts a fixed sequence. First the controller parks the core on the system clock. Next it writes the trim code for the requested operating point. Then it waits a settle interval. Only after that does it select the oscillator. Host suspend and resume pulses act as built-in requests: suspend selects the 32 kHz clock, and resume selects the high-speed oscillator point.

A request that arrives while a switch is in progress is not dropped. It is held and serviced once the switch completes. A later request overwrites an earlier held one.

Top module: `clksel_park_ctrl`

## Requirements
- R1: After reset, src_sel_o is 0 (system clock), div2_o is 0, busy_o is 0 and trim_wr_o is 0.
- R2: Source codes 0 (system), 1 (32 kHz) and 2 (oscillator 1) are applied on the clock edge that accepts the request, with div2_o = 0.
- R3: Code 3 (oscillator 2, low speed) ends with src_sel_o = 3 and div2_o = 1. Code 4 (oscillator 2, high speed) ends with src_sel_o = 4 and div2_o = 0. div2_o is 1 only while src_sel_o is 3.
- R4: On the edge that accepts a code 3 or 4 request, src_sel_o goes to 0 with div2_o = 0. It stays there until the oscillator is selected.
- R5: One cycle after parking, trim_wr_o pulses high for exactly one cycle. While it is high, trim_o carries trim_lo_i for code 3 or trim_hi_i for code 4.
- R6: The oscillator selection (src_sel_o and div2_o together, on the same edge) happens exactly SETTLE_CYC cycles after the cycle in which trim_wr_o is high.
- R7: A suspend_i pulse acts as a request for code 1, and a resume_i pulse acts as a request for code 4. When several requests arrive in one cycle, suspend_i wins over resume_i, and resume_i wins over req_valid_i.
- R8: Codes 5, 6 and 7 select the system clock (src_sel_o = 0) with div2_o = 0.
- R9: busy_o rises on the edge that accepts a request. It stays high until the first edge after the final selection at which sel_ack_i is 1.
- R10: A request that arrives while busy_o is high is held and carried out after the current switch completes, without busy_o dropping in between. If several requests arrive, the latest one is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | One-cycle request strobe |
| req_src_i | input | 3 | Requested source code (0..4 defined, 5..7 fall back to system) |
| suspend_i | input | 1 | Host suspend event pulse |
| resume_i | input | 1 | Host resume event pulse |
| trim_lo_i | input | TRIM_W | Trim code for the low-speed operating point |
| trim_hi_i | input | TRIM_W | Trim code for the high-speed operating point |
| sel_ack_i | input | 1 | Mux reports that the latest selection is live |
| src_sel_o | output | 3 | Selected source code to the clock mux |
| div2_o | output | 1 | Divide-by-two enable for the selected clock |
| trim_o | output | TRIM_W | Trim code written to the oscillator |
| trim_wr_o | output | 1 | One-cycle trim write strobe |
| busy_o | output | 1 | Switch in progress or request held |

## Verification
The assertions assume that suspend_i, resume_i and req_valid_i are single-cycle strobes. They also assume that sel_ack_i eventually rises after each selection, so a switch does not stay busy forever. The bench drives every strobe for exactly one cycle, between falling edges. It holds sel_ack_i high except in one directed case, where it keeps the acknowledge low for a while on purpose. Trim inputs are kept constant during a sequence, so the code seen on the trim pulse can be predicted.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        SRC_SYS     = 3'd0,
        SRC_SLOW    = 3'd1,
        SRC_OSC1    = 3'd2,
        SRC_OSC2_LO = 3'd3,
        SRC_OSC2_HI = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRIM,
        ST_SETTLE,
        ST_ACK
    } st_e;

    // Map a raw request code onto a source; unknown codes park on system
    function automatic src_e decode_src(logic [CODE_W-1:0] code);
        case (code)
            3'd1:    return SRC_SLOW;
            3'd2:    return SRC_OSC1;
            3'd3:    return SRC_OSC2_LO;
            3'd4:    return SRC_OSC2_HI;
            default: return SRC_SYS;
        endcase
    endfunction

    function automatic logic needs_retune(src_e s);
        return (s == SRC_OSC2_LO) || (s == SRC_OSC2_HI);
    endfunction

endpackage

// File: rtl/clksel_req_arb.sv
module clksel_req_arb
    import clksel_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [CODE_W-1:0] req_src_i,
    input  logic              suspend_i,
    input  logic              resume_i,
    input  logic              take_i,
    output logic              launch_v_o,
    output logic [CODE_W-1:0] launch_code_o,
    output logic              held_o
);

    typedef struct packed {
        logic              v;
        logic [CODE_W-1:0] code;
    } hold_t;

    hold_t hold_d, hold_q;
    logic              in_v;
    logic [CODE_W-1:0] in_code;

    always_comb begin
        in_v    = suspend_i | resume_i | req_valid_i;
        if (suspend_i)     in_code = SRC_SLOW;
        else if (resume_i) in_code = SRC_OSC2_HI;
        else               in_code = req_src_i;

        launch_v_o    = in_v | hold_q.v;
        launch_code_o = in_v ? in_code : hold_q.code;

        hold_d = hold_q;
        if (take_i) begin
            hold_d.v = 1'b0;
        end else if (in_v) begin
            hold_d.v    = 1'b1;
            hold_d.code = in_code;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q <= '0;
        else         hold_q <= hold_d;
    end

    assign held_o = hold_q.v;

endmodule

// File: rtl/clksel_settle_timer.sv
module clksel_settle_timer #(
    parameter int SETTLE_CYC = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic done_o
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        done_o = tmr_q.run && (tmr_q.cnt == LAST);
        if (start_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (done_o) begin
            tmr_d.run = 1'b0;
        end else if (tmr_q.run) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

endmodule

// File: rtl/clksel_park_ctrl.sv
module clksel_park_ctrl
    import clksel_pkg::*;
#(
    parameter int TRIM_W     = 7,
    parameter int SETTLE_CYC = 5000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [2:0]        req_src_i,
    input  logic              suspend_i,
    input  logic              resume_i,
    input  logic [TRIM_W-1:0] trim_lo_i,
    input  logic [TRIM_W-1:0] trim_hi_i,
    input  logic              sel_ack_i,
    output logic [2:0]        src_sel_o,
    output logic              div2_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic              trim_wr_o,
    output logic              busy_o
);

    typedef struct packed {
        st_e               st;
        src_e              tgt;
        src_e              src;
        logic              div2;
        logic [TRIM_W-1:0] trim;
        logic              trim_wr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              take;
    logic              launch_v;
    logic [CODE_W-1:0] launch_code;
    logic              held;
    logic              tmr_start;
    logic              tmr_done;
    src_e              nxt_tgt;

    clksel_req_arb u_arb (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .req_valid_i   (req_valid_i),
        .req_src_i     (req_src_i),
        .suspend_i     (suspend_i),
        .resume_i      (resume_i),
        .take_i        (take),
        .launch_v_o    (launch_v),
        .launch_code_o (launch_code),
        .held_o        (held)
    );

    clksel_settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (tmr_start),
        .done_o  (tmr_done)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.trim_wr = 1'b0;
        take          = 1'b0;
        tmr_start     = 1'b0;
        nxt_tgt       = decode_src(launch_code);
        case (ctl_q.st)
            ST_IDLE: begin
                if (launch_v) begin
                    take      = 1'b1;
                    ctl_d.tgt = nxt_tgt;
                    ctl_d.div2 = 1'b0;
                    if (needs_retune(nxt_tgt)) begin
                        ctl_d.src = SRC_SYS;
                        ctl_d.st  = ST_TRIM;
                    end else begin
                        ctl_d.src = nxt_tgt;
                        ctl_d.st  = ST_ACK;
                    end
                end
            end
            ST_TRIM: begin
                ctl_d.trim    = (ctl_q.tgt == SRC_OSC2_LO) ? trim_lo_i : trim_hi_i;
                ctl_d.trim_wr = 1'b1;
                tmr_start     = 1'b1;
                ctl_d.st      = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    ctl_d.src  = ctl_q.tgt;
                    ctl_d.div2 = (ctl_q.tgt == SRC_OSC2_LO);
                    ctl_d.st   = ST_ACK;
                end
            end
            ST_ACK: begin
                if (sel_ack_i) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, tgt: SRC_SYS, src: SRC_SYS,
                       div2: 1'b0, trim: '0, trim_wr: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign src_sel_o = ctl_q.src;
    assign div2_o    = ctl_q.div2;
    assign trim_o    = ctl_q.trim;
    assign trim_wr_o = ctl_q.trim_wr;
    assign busy_o    = (ctl_q.st != ST_IDLE) || held;

endmodule

// File: rtl/clksel_park_chk.sv
module clksel_park_chk #(
    parameter int TRIM_W = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sel_ack_i,
    input logic [2:0]        src_sel_o,
    input logic              div2_o,
    input logic [TRIM_W-1:0] trim_o,
    input logic              trim_wr_o,
    input logic              busy_o
);

    AST_DIV_ONLY_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div2_o |-> (src_sel_o == 3'd3)); // R3

    AST_PARK_BEFORE_TRIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(trim_wr_o) |-> (src_sel_o == 3'd0 && !div2_o)); // R4

    AST_TRIM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trim_wr_o |=> !trim_wr_o); // R5

    AST_TRIM_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trim_wr_o |-> busy_o); // R5

    AST_TRIM_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trim_wr_o && !busy_o |=> (busy_o || $stable(trim_o))); // R5

    AST_IDLE_NO_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |=> (busy_o || $stable(src_sel_o))); // R9

    AST_WAIT_FOR_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !sel_ack_i) |=> busy_o); // R9

endmodule

bind clksel_park_ctrl clksel_park_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_ack_i (sel_ack_i),
    .src_sel_o (src_sel_o),
    .div2_o    (div2_o),
    .trim_o    (trim_o),
    .trim_wr_o (trim_wr_o),
    .busy_o    (busy_o)
);

// File: tb/clksel_park_ctrl_tb_top.sv
module clksel_park_ctrl_tb_top;

    localparam int TW = 7;
    localparam int S  = 20;
    localparam logic [TW-1:0] TLO = 7'd40;
    localparam logic [TW-1:0] THI = 7'd88;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_v = 1'b0;
    logic [2:0]    req_c = '0;
    logic          susp = 1'b0;
    logic          resm = 1'b0;
    logic          ack = 1'b1;
    logic [2:0]    src;
    logic          div2;
    logic [TW-1:0] trim;
    logic          trim_wr;
    logic          busy;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    clksel_park_ctrl #(.TRIM_W(TW), .SETTLE_CYC(S)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_src_i(req_c),
        .suspend_i(susp), .resume_i(resm), .trim_lo_i(TLO), .trim_hi_i(THI),
        .sel_ack_i(ack), .src_sel_o(src), .div2_o(div2), .trim_o(trim),
        .trim_wr_o(trim_wr), .busy_o(busy)
    );

    // code, expected source, expected divide-by-two
    localparam logic [6:0] VEC [0:9] = '{
        {3'd1, 3'd1, 1'b0}, {3'd2, 3'd2, 1'b0}, {3'd3, 3'd3, 1'b1},
        {3'd0, 3'd0, 1'b0}, {3'd4, 3'd4, 1'b0}, {3'd5, 3'd0, 1'b0},
        {3'd2, 3'd2, 1'b0}, {3'd6, 3'd0, 1'b0}, {3'd3, 3'd3, 1'b1},
        {3'd7, 3'd0, 1'b0}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] c, input logic s, input logic r, input logic v);
        @(negedge clk);
        req_c = c; susp = s; resm = r; req_v = v;
        @(negedge clk);
        req_v = 1'b0; susp = 1'b0; resm = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(src == 3'd0, "R1 src", src, 0);
        check(!div2 && !busy && !trim_wr, "R1 div/busy/trim_wr", {div2, busy, trim_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2, R3, R8
        for (int k = 0; k < 10; k++) begin
            send(VEC[k][6:4], 1'b0, 1'b0, 1'b1);
            check(busy, "R9 busy after accept", busy, 1);
            wait_idle();
            check(src == VEC[k][3:1], "R2/R3/R8 src", src, VEC[k][3:1]);
            check(div2 == VEC[k][0], "R3 div2", div2, VEC[k][0]);
        end

        // R2 direct apply on accepting edge, busy clears the next cycle
        send(3'd2, 1'b0, 1'b0, 1'b1);
        check(src == 3'd2, "R2 immediate src", src, 2);
        @(negedge clk);
        check(!busy, "R9 busy cleared", busy, 0);

        // R4/R5/R6 parked sequence for high speed
        send(3'd4, 1'b0, 1'b0, 1'b1);
        check(src == 3'd0 && !div2, "R4 parked on system", src, 0);
        check(!trim_wr, "R5 no trim yet", trim_wr, 0);
        @(negedge clk);
        check(trim_wr, "R5 trim pulse", trim_wr, 1);
        check(trim == THI, "R5 trim hi code", trim, THI);
        begin
            int n;
            n = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                n++;
                if (i == 0) check(!trim_wr, "R5 single pulse", trim_wr, 0);
                if (src != 3'd0) break;
            end
            check(n == S, "R6 settle length", n, S);
            check(src == 3'd4 && !div2, "R6 hi selected", src, 4);
        end
        wait_idle();

        // R5/R6 low speed trim and divider together
        send(3'd3, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check(trim == TLO, "R5 trim lo code", trim, TLO);
        repeat (S - 1) @(negedge clk);
        check(src == 3'd0 && !div2, "R6 still parked", src, 0);
        @(negedge clk);
        check(src == 3'd3 && div2, "R6 lo and div2 same edge", {src, div2}, 7);
        wait_idle();

        // R7 suspend, resume, priority
        send(3'd2, 1'b1, 1'b1, 1'b1);
        wait_idle();
        check(src == 3'd1, "R7 suspend wins", src, 1);
        send(3'd2, 1'b0, 1'b1, 1'b1);
        check(src == 3'd0, "R7 resume parks", src, 0);
        wait_idle();
        check(src == 3'd4, "R7 resume selects hi", src, 4);

        // R10 held requests, latest kept, busy stays high
        send(3'd3, 1'b0, 1'b0, 1'b1);
        send(3'd1, 1'b0, 1'b0, 1'b1);
        send(3'd2, 1'b0, 1'b0, 1'b1);
        begin
            int drops;
            drops = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (src == 3'd2) break;
                if (!busy) drops++;
            end
            check(drops == 0, "R10 busy held across pending", drops, 0);
        end
        check(src == 3'd2, "R10 latest request served", src, 2);
        wait_idle();
        check(src == 3'd2, "R10 earlier request dropped", src, 2);

        // R9 busy held while acknowledge is low
        ack = 1'b0;
        send(3'd1, 1'b0, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        check(busy, "R9 waits for ack", busy, 1);
        ack = 1'b1;
        @(negedge clk);
        check(!busy, "R9 ack completes", busy, 0);

        // R1 reset in the middle of a parked switch
        send(3'd4, 1'b0, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(src == 3'd0 && !busy, "R1 reset mid-switch", {src, busy}, 0);
        rst_n = 1'b1;
        repeat (S + 5) @(negedge clk);
        check(src == 3'd0 && !busy, "R1 no resume after reset", {src, busy}, 0);

        summary();
        $finish;
    end

endmodule